// File: doc/BRIEF.md
# Xoroshiro128+ Random Word Generator

This block is a non-cryptographic pseudo-random source built on the xoroshiro128+ recurrence. It holds 128 bits of state as two 64-bit halves. A single load cycle writes that state from a 128-bit seed. A single request cycle then produces one random word of `OUT_W` bits. Each generation step yields the 64-bit sum of the two halves and moves the state forward by one step of the recurrence. The recurrence has a period of 2^128 - 1.

Words wider than 64 bits take several consecutive steps. The first 64-bit result ends up in the most significant position. When `OUT_W` is not a multiple of 64, only the top `OUT_W` bits of the concatenation are kept. A one-cycle `ready_o` pulse marks the cycle in which a new word is presented. That word then stays on `rand_o` until the next word completes.

Control is a three-state machine:
- **IDLE**: waits for a request. The transition *accept* moves it to FILL when `req_i` is high and `load_i` is low.
- **FILL**: takes one 64-bit result per cycle. It loops on itself through *step*. After the last result, the transition *finish* moves it to SHOW.
- **SHOW**: raises `ready_o` for one cycle. The transition *retire* then returns it to IDLE.

The transition *reseed* goes from any state back to IDLE whenever `load_i` is high.

Top module: `xr_rng`

## Requirements
- R1: When `load_i` is high on a clock edge, the state becomes s0 = `seed_i[127:64]` and s1 = `seed_i[63:0]`. The controller returns to IDLE. Any word under construction is abandoned, so `ready_o` is low in the next cycle and `rand_o` keeps its old value. A request in the same cycle as a load is dropped.
- R2: One generation step produces (s0 + s1) mod 2^64. It then updates the state in this order: t = s1 ^ s0; s0 = rotl(s0,55) ^ t ^ (t << 14); s1 = rotl(t,36).
- R3: A request accepted in IDLE runs ceil(`OUT_W`/64) steps on consecutive cycles, starting with the edge after the accepting edge. Within the concatenation, the first result is the most significant 64 bits.
- R4: If `OUT_W` is not a multiple of 64, `rand_o` carries the top `OUT_W` bits of the concatenated results. The low bits of the last result are discarded.
- R5: `ready_o` is high for exactly one cycle: the cycle after the edge that takes the last result. `rand_o` changes only on that edge and holds until the next completion.
- R6: `req_i` is ignored in FILL and in SHOW. A request is accepted again only once the controller is back in IDLE.
- R7: An all-zero seed is replaced by the state s0 = 64'h9E3779B97F4A7C15, s1 = 64'hBF58476D1CE4E5B9. The 128-bit state is never zero.
- R8: Reset is active-low and asynchronous. It puts the controller in IDLE, sets `ready_o` = 0 and `rand_o` = 0, and loads the R7 substitute state.
- R9: The state changes only on a load or on a generation step. It is unchanged in IDLE and SHOW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Seed the state from `seed_i` and abort any word |
| req_i | input | 1 | Request one random word (taken in IDLE only) |
| seed_i | input | 128 | Seed; upper half goes to s0, lower half to s1 |
| ready_o | output | 1 | One-cycle pulse: a new word is on `rand_o` |
| rand_o | output | OUT_W | Most recent completed random word |

## Verification
Two functions can fall in the same cycle: a reseed and a request, or a reseed and a generation step. Both cases are provoked for every width (32, 64, 100 and 128).

The first case raises `load_i` and `req_i` together. The second raises `load_i` while a wide word is still filling. A behavioural xoroshiro128+ model in the bench is compared with `ready_o` and `rand_o` on every clock. Correct handling means three things in both cases:
- no ready pulse appears;
- `rand_o` keeps its old value;
- every later word follows the new seed.

// File: rtl/xr_pkg.sv
package xr_pkg;
    localparam int XR_WORD_W  = 64;
    localparam int XR_STATE_W = 2 * XR_WORD_W;

    // Substitute state used after reset and in place of an all-zero seed
    localparam logic [XR_WORD_W-1:0] XR_FALLBACK_S0 = 64'h9E3779B97F4A7C15;
    localparam logic [XR_WORD_W-1:0] XR_FALLBACK_S1 = 64'hBF58476D1CE4E5B9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SHOW = 2'd2
    } xr_state_e;
endpackage

// File: rtl/xr_state.sv
module xr_state
    import xr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [XR_STATE_W-1:0] seed_i,
    input  logic                  adv_i,
    output logic [XR_WORD_W-1:0]  word_o
);
    logic [XR_WORD_W-1:0] s0_q, s1_q;
    logic [XR_WORD_W-1:0] mix, s0_n, s1_n;
    logic                 seed_zero;

    assign seed_zero = (seed_i == '0);

    always_comb begin
        mix  = s1_q ^ s0_q;
        s0_n = {s0_q[8:0], s0_q[63:9]} ^ mix ^ (mix << 14);
        s1_n = {mix[27:0], mix[63:28]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0_q <= XR_FALLBACK_S0;
            s1_q <= XR_FALLBACK_S1;
        end else if (load_i) begin
            if (seed_zero) begin
                s0_q <= XR_FALLBACK_S0;
                s1_q <= XR_FALLBACK_S1;
            end else begin
                s0_q <= seed_i[XR_STATE_W-1:XR_WORD_W];
                s1_q <= seed_i[XR_WORD_W-1:0];
            end
        end else if (adv_i) begin
            s0_q <= s0_n;
            s1_q <= s1_n;
        end
    end

    assign word_o = s0_q + s1_q;

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(s0_q) && $stable(s1_q))); // R9
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ({s0_q, s1_q} != '0)); // R7
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !seed_zero) |=> ({s0_q, s1_q} == $past(seed_i))); // R1
endmodule

// File: rtl/xr_ctrl.sv
module xr_ctrl
    import xr_pkg::*;
#(
    parameter int NWORDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic req_i,
    output logic take_o,
    output logic last_o,
    output logic ready_o
);
    localparam int CW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    xr_state_e       st_q;
    logic [CW-1:0]   cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (load_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_i) begin
                        st_q  <= ST_FILL;
                        cnt_q <= '0;
                    end
                end
                ST_FILL: begin
                    if (cnt_q == CW'(NWORDS - 1)) begin
                        st_q  <= ST_SHOW;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SHOW: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        take_o  = (st_q == ST_FILL) && !load_i;
        last_o  = take_o && (cnt_q == CW'(NWORDS - 1));
        ready_o = (st_q == ST_SHOW);
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o); // R5
    AST_LOAD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q == ST_IDLE && !ready_o)); // R1
    AST_FILL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && !last_o && !load_i) |=> (st_q == ST_FILL)); // R6
    AST_SHOW_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHOW) |=> (st_q == ST_IDLE)); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) < NWORDS)); // R3
endmodule

// File: rtl/xr_pack.sv
module xr_pack
    import xr_pkg::*;
#(
    parameter int OUT_W  = 100,
    parameter int NWORDS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_i,
    input  logic                 last_i,
    input  logic [XR_WORD_W-1:0] word_i,
    output logic [OUT_W-1:0]     rand_o
);
    localparam int BW = NWORDS * XR_WORD_W;

    logic [BW-1:0]    acc_q;
    logic [BW-1:0]    full;
    logic [OUT_W-1:0] out_q;

    // Newest result enters at the bottom, so the first one ends on top
    assign full = BW'({acc_q, word_i});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            out_q <= '0;
        end else if (take_i) begin
            acc_q <= full;
            if (last_i) out_q <= full[BW-1 -: OUT_W];
        end
    end

    assign rand_o = out_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(rand_o)); // R5
endmodule

// File: rtl/xr_rng.sv
module xr_rng
    import xr_pkg::*;
#(
    parameter int OUT_W = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  req_i,
    input  logic [XR_STATE_W-1:0] seed_i,
    output logic                  ready_o,
    output logic [OUT_W-1:0]      rand_o
);
    localparam int NWORDS = (OUT_W + XR_WORD_W - 1) / XR_WORD_W;

    logic                 take, last;
    logic [XR_WORD_W-1:0] word;

    xr_ctrl #(.NWORDS(NWORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .req_i(req_i),
        .take_o(take), .last_o(last), .ready_o(ready_o)
    );

    xr_state u_state (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
        .adv_i(take), .word_o(word)
    );

    xr_pack #(.OUT_W(OUT_W), .NWORDS(NWORDS)) u_pack (
        .clk(clk), .rst_n(rst_n), .take_i(take), .last_i(last),
        .word_i(word), .rand_o(rand_o)
    );

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> ready_o); // R5
endmodule

// File: tb/sim_xr_rng.sv
`timescale 1ns/1ps
module sim_xr_rng;
    localparam int WV [4] = '{32, 64, 100, 128};
    localparam logic [63:0] FB0 = 64'h9E3779B97F4A7C15;
    localparam logic [63:0] FB1 = 64'hBF58476D1CE4E5B9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [3:0]   req = 4'b0;
    logic [127:0] seed = '0;
    logic [3:0]   rdy;
    logic [31:0]  r32;
    logic [63:0]  r64;
    logic [99:0]  r100;
    logic [127:0] r128;
    logic [127:0] got [4];

    int checks = 0, fails = 0;
    int pulses [4];
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    xr_rng #(.OUT_W(100)) u0 (.clk(clk), .rst_n(rst_n), .load_i(load), .req_i(req[2]),
        .seed_i(seed), .ready_o(rdy[2]), .rand_o(r100));
    xr_rng #(.OUT_W(32))  u1 (.clk(clk), .rst_n(rst_n), .load_i(load), .req_i(req[0]),
        .seed_i(seed), .ready_o(rdy[0]), .rand_o(r32));
    xr_rng #(.OUT_W(64))  u2 (.clk(clk), .rst_n(rst_n), .load_i(load), .req_i(req[1]),
        .seed_i(seed), .ready_o(rdy[1]), .rand_o(r64));
    xr_rng #(.OUT_W(128)) u3 (.clk(clk), .rst_n(rst_n), .load_i(load), .req_i(req[3]),
        .seed_i(seed), .ready_o(rdy[3]), .rand_o(r128));

    assign got[0] = {96'b0, r32};
    assign got[1] = {64'b0, r64};
    assign got[2] = {28'b0, r100};
    assign got[3] = r128;

    // Behavioural reference model
    logic [63:0]  ms0 [4], ms1 [4];
    logic [255:0] macc [4];
    logic [127:0] mrand [4];
    logic         mready [4];
    int           mleft [4];

    always @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < 4; i++) begin
            if (!rst_n) begin
                ms0[i] = FB0; ms1[i] = FB1; mleft[i] = 0;      // R8
                mready[i] = 1'b0; mrand[i] = '0; macc[i] = '0;
            end else if (load) begin                           // R1
                if (seed == '0) begin ms0[i] = FB0; ms1[i] = FB1; end  // R7
                else begin ms0[i] = seed[127:64]; ms1[i] = seed[63:0]; end
                mleft[i] = 0; mready[i] = 1'b0;
            end else begin
                automatic bit   idle = (mleft[i] == 0) && !mready[i];
                automatic int   nw   = (WV[i] + 63) / 64;
                automatic logic [63:0] w, t;
                automatic logic [255:0] mask;
                mready[i] = 1'b0;
                if (mleft[i] > 0) begin                        // R2 R3
                    w = ms0[i] + ms1[i];
                    t = ms1[i] ^ ms0[i];
                    ms0[i] = ((ms0[i] << 55) | (ms0[i] >> 9)) ^ t ^ (t << 14);
                    ms1[i] = (t << 36) | (t >> 28);
                    macc[i] = (macc[i] << 64) | {192'b0, w};
                    mleft[i]--;
                    if (mleft[i] == 0) begin                   // R4 R5
                        mask = {256{1'b1}} >> (256 - WV[i]);
                        mrand[i] = 128'((macc[i] >> (nw * 64 - WV[i])) & mask);
                        mready[i] = 1'b1;
                    end
                end else if (idle && req[i]) begin             // R6: busy ignores
                    mleft[i] = nw;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) begin
                checks++;
                if (rdy[i] !== mready[i]) begin
                    fails++;
                    $display("FAIL R5 width %0d ready: got %b expected %b", WV[i], rdy[i], mready[i]);
                end
                checks++;
                if (got[i] !== mrand[i]) begin
                    fails++;
                    $display("FAIL R2 R3 R4 R9 width %0d rand: got %h expected %h", WV[i], got[i], mrand[i]);
                end
                if (rdy[i]) pulses[i]++;
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reseed(logic [127:0] s);
        seed = s; load = 1'b1; cyc(1); load = 1'b0;
    endtask

    task automatic ask(logic [3:0] m);
        req = m; cyc(1); req = 4'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) pulses[i] = 0;
        cyc(3);
        // R8: reset values
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (rdy[i] !== 1'b0 || got[i] !== '0) begin
                fails++;
                $display("FAIL R8 width %0d reset: got %b/%h expected 0/0", WV[i], rdy[i], got[i]);
            end
        end
        rst_n = 1'b1;
        cyc(1);
        // generation from the reset state (R8 substitute state)
        ask(4'hF); cyc(5);
        // R2 R3 R4: explicit seed
        reseed(128'h0123456789ABCDEF_FEDCBA9876543210);
        ask(4'hF); cyc(5);
        // R6: request held high across busy cycles
        req = 4'hF; cyc(30); req = 4'b0; cyc(4);
        // R7: zero seed
        reseed('0);
        ask(4'hF); cyc(5);
        ask(4'hF); cyc(5);
        // R1: load while a wide word is filling
        ask(4'hF); cyc(1);
        reseed(128'hDEADBEEFCAFEF00D_0000000000000001);
        cyc(4);
        ask(4'hF); cyc(5);
        // R1: load and request in the same cycle
        seed = 128'h00000000000000FF_8000000000000000;
        load = 1'b1; req = 4'hF; cyc(1); load = 1'b0; req = 4'b0;
        cyc(4);
        ask(4'hF); cyc(5);
        // R1: load on the ready cycle
        ask(4'hF); cyc(2);
        reseed(128'h1);
        cyc(3);
        // R9: varied seeds and staggered requests
        for (int k = 1; k <= 5; k++) begin
            reseed({64'(k) * 64'h9E3779B97F4A7C15, 64'(k) ^ 64'hFFFF0000FFFF0000});
            ask(4'b0101); ask(4'b1010); cyc(3);
            ask(4'hF); cyc(1); ask(4'hF); cyc(4);
        end
        cyc(3);
        // R5: every width completed words
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (pulses[i] < 10) begin
                fails++;
                $display("FAIL R5 width %0d pulses: got %0d expected at least 10", WV[i], pulses[i]);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule